// File: doc/BRIEF.md
# T=0 Command Header and Procedure-Byte Engine

This block is the card-side transport engine for the character-oriented T=0 protocol. It takes single characters from a receiving UART. It gathers the five-byte command header (class, instruction, two parameters and a length byte) and presents the finished header to a host-side agent in a single cycle. After the header it turns the line around. It sends whatever procedure bytes, data and status words the host supplies, through a valid/ready transmit port.

The host never drives direction control directly. Each byte it offers carries sideband flags that say what happens after that byte: keep transmitting, switch to receiving data from the reader, or end the exchange. In receive mode the engine forwards every incoming data byte to the host and counts it against the length byte. When the count is complete it marks the last byte as final and returns to transmit mode so the host can send the status words.

While the card owes the reader a byte and the host is silent, a waiting-time timer runs. At half the programmed waiting time the engine sends a NULL procedure byte (0x60) on its own, so that the reader keeps waiting. A 0xFF arriving where a class byte is expected is handed off to separate protocol-parameter negotiation logic.

Top module: `t0_link_ctrl`

## Requirements
- R1: After reset the engine waits for a class byte: `line_rx_en`=1, `line_tx_en`=0, and `tx_valid`, `hin_ready`, `hdr_valid`, `fwd_valid` and `pps_divert` are all 0.
- R2: The five header bytes are stored in arrival order. In the cycle after the fifth byte is accepted, `hdr_valid` is high for exactly one cycle. `hdr_bus` then holds class in bits 39:32, instruction in 31:24, P1 in 23:16, P2 in 15:8 and the length byte P3 in 7:0.
- R3: `line_rx_en` is 1 while collecting header bytes or receiving data. `line_tx_en` is 1 while waiting to send a procedure byte or while transmitting data. The two are never 1 together.
- R4: In the two transmit states, a host byte offered with `hin_valid` appears on `tx_data` with `tx_valid`=1, and `hin_ready` follows `tx_ready`. In every other state `hin_ready` and `tx_valid` are 0.
- R5: When a procedure byte is accepted, the flags decide the next state. If `hin_flags` bit 0 is set, the engine moves to transmit-data. Otherwise, if bit 1 is set, it moves to receive-data with the receiver enabled. Bit 0 wins when both are set.
- R6: In receive-data, each incoming byte appears on `fwd_data` with `fwd_valid` one cycle later. The expected count is P3, and a P3 of 0 counts as 256. The byte that completes the count has `fwd_final`=1, and the engine moves to transmit-data in the same clock.
- R7: A host byte accepted with `hin_last`=1 and `hin_flags` bit 2 (final) set ends the exchange and returns to waiting for a class byte. This applies in transmit-data, and in the procedure-byte state when neither direction bit is set.
- R8: In either transmit state with no host byte offered, once half of `WT_CYCLES` clock cycles have passed without a character, `tx_valid` rises with `tx_data`=0x60. Every character sent or received restarts this timer.
- R9: If a host byte is offered in the same cycle that the NULL byte falls due, the host byte is sent and the NULL byte is not sent.
- R10: A NULL byte that is due but not accepted (`tx_ready`=0) stays offered unchanged until it is accepted or a host byte replaces it.
- R11: A 0xFF received while waiting for a class byte pulses `pps_divert` in the next cycle. The engine then drives both line enables low until `pps_done`, and returns to waiting for a class byte.
- R12: Bytes that arrive while the engine is transmitting or handed off for negotiation never reach the header or the data forwarding outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Character received from the line this cycle |
| rx_data | input | 8 | Received character |
| tx_valid | output | 1 | Character offered to the transmitting UART |
| tx_data | output | 8 | Character to transmit |
| tx_ready | input | 1 | UART accepts the offered character |
| line_rx_en | output | 1 | Receiver enable for the UART |
| line_tx_en | output | 1 | Transmitter enable for the UART |
| hdr_valid | output | 1 | One-cycle strobe: complete command header available |
| hdr_bus | output | 40 | Command header, class byte most significant |
| hin_valid | input | 1 | Host offers a byte to send |
| hin_data | input | 8 | Host byte |
| hin_flags | input | 3 | Bit 0 go-transmit, bit 1 go-receive, bit 2 final |
| hin_last | input | 1 | Host byte is the last one of its record |
| hin_ready | output | 1 | Host byte is taken this cycle |
| fwd_valid | output | 1 | Received data byte forwarded to host |
| fwd_data | output | 8 | Forwarded data byte |
| fwd_final | output | 1 | Forwarded byte completes the expected count |
| pps_divert | output | 1 | One-cycle strobe: negotiation request start seen |
| pps_done | input | 1 | Negotiation logic returns the line |

## Verification
The collision that matters is a host byte turning up in the very cycle the waiting-time timer reaches its half point. In that cycle both the host path and the NULL generator want the single transmit port. The bench provokes this by sending a header and then sweeping the host's delay across the cycles on either side of the half-time point. It also holds `tx_ready` low so that a pending NULL byte and a late host byte overlap. A behavioural reference model predicts, for every clock, which of the two characters is on `tx_data` and when the timer restarts. Each port is compared against that prediction, so a NULL byte that leaks out or a host byte that is dropped is seen in the exact cycle it happens.

// File: rtl/t0_link_pkg.sv
package t0_link_pkg;

   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned HDR_N   = 5;
   localparam logic [BYTE_W-1:0] NULL_PB   = 8'h60;
   localparam logic [BYTE_W-1:0] PPS_START = 8'hFF;

   // header states first, encoded so their value is the header slot index
   typedef enum logic [3:0] {
      ST_CLA = 4'd0,
      ST_INS = 4'd1,
      ST_P1  = 4'd2,
      ST_P2  = 4'd3,
      ST_P3  = 4'd4,
      ST_PB  = 4'd5,
      ST_RX  = 4'd6,
      ST_TX  = 4'd7,
      ST_PPS = 4'd8
   } t0_state_e;

   typedef struct packed {
      logic final_rec;
      logic go_rx;
      logic go_tx;
   } t0_flags_t;

endpackage

// File: rtl/t0_hdr_capture.sv
module t0_hdr_capture
   import t0_link_pkg::*;
#(
   parameter int unsigned SLOTS = HDR_N
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [$clog2(SLOTS)-1:0]   wr_idx,
   input  logic [BYTE_W-1:0]          wr_data,
   output logic                       hdr_valid,
   output logic [SLOTS*BYTE_W-1:0]    hdr_bus
);
   localparam int unsigned IDX_W = $clog2(SLOTS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic [BYTE_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (wr_en && (wr_idx == IDX_W'(g)))
            slot_q <= wr_data;
      end
      assign hdr_bus[(SLOTS-1-g)*BYTE_W +: BYTE_W] = slot_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hdr_valid <= 1'b0;
      else
         hdr_valid <= wr_en && (wr_idx == LAST_IDX);
   end

endmodule

// File: rtl/t0_wait_timer.sv
module t0_wait_timer #(
   parameter int unsigned WT_CYCLES = 9600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic char_evt,
   output logic null_due
);
   localparam int unsigned HALF  = WT_CYCLES / 2;
   localparam int unsigned CNT_W = $clog2(HALF + 1);
   localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!active || char_evt)
         cnt_q <= '0;
      else if (cnt_q != HALF_C)
         cnt_q <= cnt_q + 1'b1;
   end

   assign null_due = active && (cnt_q == HALF_C);

endmodule

// File: rtl/t0_len_counter.sv
module t0_len_counter
   import t0_link_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_val,
   input  logic              dec,
   output logic              last
);
   localparam int unsigned LEN_W = BYTE_W + 1;
   localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(1 << BYTE_W);

   logic [LEN_W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rem_q <= '0;
      else if (load)
         rem_q <= (load_val == '0) ? FULL_LEN : {1'b0, load_val};
      else if (dec && (rem_q != '0))
         rem_q <= rem_q - 1'b1;
   end

   assign last = (rem_q == LEN_W'(1));

endmodule

// File: rtl/t0_link_ctrl.sv
module t0_link_ctrl
   import t0_link_pkg::*;
#(
   parameter int unsigned WT_CYCLES = 9600
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_valid,
   input  logic [7:0]  rx_data,
   output logic        tx_valid,
   output logic [7:0]  tx_data,
   input  logic        tx_ready,
   output logic        line_rx_en,
   output logic        line_tx_en,
   output logic        hdr_valid,
   output logic [39:0] hdr_bus,
   input  logic        hin_valid,
   input  logic [7:0]  hin_data,
   input  logic [2:0]  hin_flags,
   input  logic        hin_last,
   output logic        hin_ready,
   output logic        fwd_valid,
   output logic [7:0]  fwd_data,
   output logic        fwd_final,
   output logic        pps_divert,
   input  logic        pps_done
);
   localparam int unsigned IDX_W = $clog2(HDR_N);

   if (WT_CYCLES < 4) begin : g_bad_wt
      $error("t0_link_ctrl: WT_CYCLES must be at least 4");
   end
   if (HDR_N * BYTE_W != 40) begin : g_bad_hdr
      $error("t0_link_ctrl: header bus width mismatch");
   end

   t0_state_e st_q, st_n;
   t0_flags_t flg;
   logic [3:0] st_bits;
   logic in_hdr, in_tx, is_pps, hdr_wr, rx_data_take;
   logic null_due, fire, host_fire, char_evt, len_last;

   assign flg          = t0_flags_t'(hin_flags);
   assign st_bits      = st_q;
   assign in_hdr       = (st_q == ST_CLA) || (st_q == ST_INS) || (st_q == ST_P1) ||
                         (st_q == ST_P2)  || (st_q == ST_P3);
   assign in_tx        = (st_q == ST_PB) || (st_q == ST_TX);
   assign is_pps       = rx_valid && (st_q == ST_CLA) && (rx_data == PPS_START);
   assign hdr_wr       = rx_valid && in_hdr && !is_pps;
   assign rx_data_take = rx_valid && (st_q == ST_RX);

   // transmit port: host byte has priority over the NULL filler
   assign tx_valid  = in_tx && (hin_valid || null_due);
   assign tx_data   = hin_valid ? hin_data : NULL_PB;
   assign hin_ready = in_tx && tx_ready;
   assign fire      = tx_valid && tx_ready;
   assign host_fire = fire && hin_valid;
   assign char_evt  = rx_valid || fire;

   assign line_rx_en = in_hdr || (st_q == ST_RX);
   assign line_tx_en = in_tx;

   always_comb begin
      st_n = st_q;
      case (st_q)
         ST_CLA: if (rx_valid) st_n = is_pps ? ST_PPS : ST_INS;
         ST_INS: if (rx_valid) st_n = ST_P1;
         ST_P1:  if (rx_valid) st_n = ST_P2;
         ST_P2:  if (rx_valid) st_n = ST_P3;
         ST_P3:  if (rx_valid) st_n = ST_PB;
         ST_PB: begin
            if (host_fire) begin
               if (flg.go_tx)
                  st_n = ST_TX;
               else if (flg.go_rx)
                  st_n = ST_RX;
               else if (hin_last && flg.final_rec)
                  st_n = ST_CLA;
            end
         end
         ST_TX:  if (host_fire && hin_last && flg.final_rec) st_n = ST_CLA;
         ST_RX:  if (rx_data_take && len_last) st_n = ST_TX;
         ST_PPS: if (pps_done) st_n = ST_CLA;
         default: st_n = ST_CLA;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_CLA;
         fwd_valid  <= 1'b0;
         fwd_data   <= '0;
         fwd_final  <= 1'b0;
         pps_divert <= 1'b0;
      end else begin
         st_q       <= st_n;
         fwd_valid  <= rx_data_take;
         fwd_final  <= rx_data_take && len_last;
         pps_divert <= is_pps;
         if (rx_data_take)
            fwd_data <= rx_data;
      end
   end

   t0_hdr_capture #(.SLOTS(HDR_N)) u_hdr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (hdr_wr),
      .wr_idx    (st_bits[IDX_W-1:0]),
      .wr_data   (rx_data),
      .hdr_valid (hdr_valid),
      .hdr_bus   (hdr_bus)
   );

   t0_wait_timer #(.WT_CYCLES(WT_CYCLES)) u_wt (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (in_tx),
      .char_evt (char_evt),
      .null_due (null_due)
   );

   t0_len_counter u_len (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (hdr_wr && (st_q == ST_P3)),
      .load_val (rx_data),
      .dec      (rx_data_take),
      .last     (len_last)
   );

endmodule

// File: rtl/t0_link_ctrl_chk.sv
module t0_link_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_valid,
   input logic       tx_valid,
   input logic [7:0] tx_data,
   input logic       tx_ready,
   input logic       line_rx_en,
   input logic       line_tx_en,
   input logic       hdr_valid,
   input logic       hin_valid,
   input logic [7:0] hin_data,
   input logic       hin_ready,
   input logic       fwd_valid,
   input logic       fwd_final,
   input logic       pps_divert
);

   a_r3_enables_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_rx_en && line_tx_en));

   a_r4_ready_needs_tx: assert property (@(posedge clk) disable iff (!rst_n)
      hin_ready |-> (line_tx_en && tx_ready));

   a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |=> !hdr_valid);

   a_r6_final_turns_line: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid && fwd_final) |-> line_tx_en);

   a_r9_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && hin_valid) |-> (tx_data == hin_data));

   a_r10_null_held: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && !hin_valid && !rx_valid) |=> tx_valid);

   a_r11_handoff_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      pps_divert |-> (!line_rx_en && !line_tx_en));

endmodule

bind t0_link_ctrl t0_link_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_valid   (rx_valid),
   .tx_valid   (tx_valid),
   .tx_data    (tx_data),
   .tx_ready   (tx_ready),
   .line_rx_en (line_rx_en),
   .line_tx_en (line_tx_en),
   .hdr_valid  (hdr_valid),
   .hin_valid  (hin_valid),
   .hin_data   (hin_data),
   .hin_ready  (hin_ready),
   .fwd_valid  (fwd_valid),
   .fwd_final  (fwd_final),
   .pps_divert (pps_divert)
);

// File: tb/t0_link_ctrl_bench.sv
`timescale 1ns/1ps
module t0_link_ctrl_bench;
   localparam int WT   = 40;
   localparam int HALF = WT / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic tx_valid;
   logic [7:0] tx_data;
   logic tx_ready = 1'b1;
   logic line_rx_en, line_tx_en, hdr_valid;
   logic [39:0] hdr_bus;
   logic hin_valid = 1'b0;
   logic [7:0] hin_data = '0;
   logic [2:0] hin_flags = '0;
   logic hin_last = 1'b0;
   logic hin_ready, fwd_valid, fwd_final, pps_divert;
   logic [7:0] fwd_data;
   logic pps_done = 1'b0;

   always #10 clk = ~clk;

   t0_link_ctrl #(.WT_CYCLES(WT)) u_t0_link_ctrl (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .line_rx_en(line_rx_en), .line_tx_en(line_tx_en),
      .hdr_valid(hdr_valid), .hdr_bus(hdr_bus),
      .hin_valid(hin_valid), .hin_data(hin_data), .hin_flags(hin_flags),
      .hin_last(hin_last), .hin_ready(hin_ready),
      .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_final(fwd_final),
      .pps_divert(pps_divert), .pps_done(pps_done)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   // states: 0..4 header slots, 5 procedure byte, 6 receive, 7 transmit, 8 hand-off
   int ms, mcnt, mrem;
   logic [7:0] mh [5];
   bit mhv, mfv, mff, mpps;
   logic [7:0] mfd;

   function automatic bit m_txs();
      return (ms == 5) || (ms == 7);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ms = 0; mcnt = 0; mrem = 0;
         mhv = 0; mfv = 0; mff = 0; mpps = 0; mfd = '0;
         for (int i = 0; i < 5; i++) mh[i] = '0;
      end else begin
         bit txs, tv, fire, hfire;
         txs   = m_txs();
         tv    = txs && (hin_valid || (mcnt >= HALF));
         fire  = tv && tx_ready;
         hfire = fire && hin_valid;
         mhv = 0; mfv = 0; mff = 0; mpps = 0;
         if (!txs || rx_valid || fire) mcnt = 0;
         else if (mcnt < HALF) mcnt++;
         if (ms <= 4 && rx_valid) begin
            if (ms == 0 && rx_data == 8'hFF) begin
               mpps = 1; ms = 8;
            end else begin
               mh[ms] = rx_data;
               if (ms == 4) begin
                  mhv = 1;
                  mrem = (rx_data == 0) ? 256 : int'(rx_data);
               end
               ms++;
            end
         end else if (ms == 6 && rx_valid) begin
            mfv = 1; mfd = rx_data; mff = (mrem == 1); mrem--;
            if (mff) ms = 7;
         end else if (ms == 8) begin
            if (pps_done) ms = 0;
         end else if (hfire) begin
            if (ms == 5 && hin_flags[0]) ms = 7;
            else if (ms == 5 && hin_flags[1]) ms = 6;
            else if (hin_last && hin_flags[2]) ms = 0;
         end
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         bit txs, etv;
         txs = m_txs();
         etv = txs && (hin_valid || (mcnt >= HALF));
         chk(line_rx_en == ((ms <= 4) || (ms == 6)), "R3 line_rx_en", line_rx_en, ((ms <= 4) || (ms == 6)));
         chk(line_tx_en == txs, "R3 line_tx_en", line_tx_en, txs);
         chk(tx_valid == etv, "R8/R10 tx_valid", tx_valid, etv);
         if (etv)
            chk(tx_data == (hin_valid ? hin_data : 8'h60), "R9 tx_data", tx_data, hin_valid ? hin_data : 8'h60);
         chk(hin_ready == (txs && tx_ready), "R4 hin_ready", hin_ready, (txs && tx_ready));
         chk(hdr_valid == mhv, "R2/R12 hdr_valid", hdr_valid, mhv);
         if (mhv)
            chk(hdr_bus == {mh[0], mh[1], mh[2], mh[3], mh[4]}, "R2 hdr_bus", hdr_bus, {mh[0], mh[1], mh[2], mh[3], mh[4]});
         chk(fwd_valid == mfv, "R6/R12 fwd_valid", fwd_valid, mfv);
         if (mfv) begin
            chk(fwd_data == mfd, "R6 fwd_data", fwd_data, mfd);
            chk(fwd_final == mff, "R6 fwd_final", fwd_final, mff);
         end
         chk(pps_divert == mpps, "R11 pps_divert", pps_divert, mpps);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic rx_byte(input logic [7:0] d);
      rx_valid = 1'b1; rx_data = d;
      @(posedge clk); #1;
      rx_valid = 1'b0;
   endtask

   task automatic header(input logic [7:0] c, input logic [7:0] i, input logic [7:0] a,
                         input logic [7:0] b, input logic [7:0] len);
      rx_byte(c); rx_byte(i); rx_byte(a); rx_byte(b); rx_byte(len);
   endtask

   task automatic host_byte(input logic [7:0] d, input logic [2:0] f, input logic last);
      hin_valid = 1'b1; hin_data = d; hin_flags = f; hin_last = last;
      forever begin
         @(negedge clk);
         if (hin_ready) break;
      end
      @(posedge clk); #1;
      hin_valid = 1'b0; hin_flags = '0; hin_last = 1'b0;
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      #5 chk(line_rx_en && !line_tx_en && !tx_valid && !hin_ready && !hdr_valid && !fwd_valid && !pps_divert,
             "R1 reset state", {line_rx_en, line_tx_en, tx_valid, hin_ready}, 4'b1000);
      idle(2);

      // outgoing data: header, procedure byte with go-transmit, data, status
      header(8'hA0, 8'hB0, 8'h01, 8'h02, 8'h04);
      #5 chk(hdr_valid && hdr_bus == 40'hA0B0010204, "R2 header push", hdr_bus, 40'hA0B0010204);
      chk(line_tx_en && !line_rx_en, "R3 turnaround", {line_rx_en, line_tx_en}, 2'b01);
      host_byte(8'hB0, 3'b001, 1'b0);
      #5 chk(line_tx_en, "R5 go-transmit", line_tx_en, 1);
      for (int k = 0; k < 4; k++) host_byte(8'h10 + 8'(k), 3'b000, 1'b0);
      rx_byte(8'h77);          // ignored while transmitting
      #5 chk(!fwd_valid && line_tx_en, "R12 rx ignored in transmit", fwd_valid, 0);
      host_byte(8'h90, 3'b000, 1'b0);
      host_byte(8'h00, 3'b100, 1'b1);
      #5 chk(line_rx_en && !line_tx_en, "R7 final returns to class", {line_rx_en, line_tx_en}, 2'b10);

      // incoming data: go-receive with count 3
      header(8'h00, 8'hD6, 8'h00, 8'h00, 8'h03);
      host_byte(8'hD6, 3'b010, 1'b1);
      #5 chk(line_rx_en && !line_tx_en, "R5 go-receive", {line_rx_en, line_tx_en}, 2'b10);
      rx_byte(8'h11); rx_byte(8'h22); rx_byte(8'h33);
      #5 chk(fwd_valid && fwd_final && fwd_data == 8'h33 && line_tx_en, "R6 final byte", {fwd_final, fwd_data}, {1'b1, 8'h33});
      host_byte(8'h90, 3'b000, 1'b0);
      host_byte(8'h00, 3'b100, 1'b1);

      // both direction flags: transmit wins
      header(8'h00, 8'hB2, 8'h00, 8'h00, 8'h01);
      host_byte(8'hB2, 3'b011, 1'b0);
      #5 chk(line_tx_en && !line_rx_en, "R5 transmit priority", {line_rx_en, line_tx_en}, 2'b01);
      host_byte(8'h5A, 3'b000, 1'b0);
      host_byte(8'h90, 3'b000, 1'b0);
      host_byte(8'h00, 3'b100, 1'b1);

      // length 0 means 256 bytes
      header(8'h00, 8'hD6, 8'h00, 8'h00, 8'h00);
      host_byte(8'hD6, 3'b010, 1'b1);
      for (int k = 0; k < 255; k++) rx_byte(8'(k));
      #5 chk(line_rx_en && !fwd_final, "R6 still receiving at 255", {line_rx_en, fwd_final}, 2'b10);
      rx_byte(8'hEE);
      #5 chk(fwd_final && line_tx_en, "R6 256th byte final", fwd_final, 1);
      host_byte(8'h90, 3'b000, 1'b0);
      host_byte(8'h00, 3'b100, 1'b1);

      // NULL filler held while the UART is busy
      tx_ready = 1'b0;
      header(8'h00, 8'hC0, 8'h00, 8'h00, 8'h02);
      idle(HALF + 3);
      #5 chk(tx_valid && tx_data == 8'h60, "R8 null due", tx_data, 8'h60);
      idle(3);
      #5 chk(tx_valid && tx_data == 8'h60, "R10 null held", {tx_valid, tx_data}, {1'b1, 8'h60});
      tx_ready = 1'b1;
      idle(2 * HALF + 5);
      host_byte(8'hC0, 3'b001, 1'b0);
      idle(HALF + 4);
      host_byte(8'h55, 3'b000, 1'b0);
      host_byte(8'h66, 3'b000, 1'b0);
      host_byte(8'h90, 3'b000, 1'b0);
      host_byte(8'h00, 3'b100, 1'b1);

      // host byte racing the half-time point
      for (int d = HALF - 3; d <= HALF + 2; d++) begin
         header(8'h00, 8'hA4, 8'h00, 8'h00, 8'h02);
         idle(d);
         host_byte(8'h6A, 3'b000, 1'b0);
         host_byte(8'h82, 3'b100, 1'b1);
         #5 chk(line_rx_en, "R9 collision sweep returns", line_rx_en, 1);
      end

      // negotiation hand-off
      rx_byte(8'hFF);
      #5 chk(pps_divert && !line_rx_en && !line_tx_en, "R11 hand-off", {pps_divert, line_rx_en, line_tx_en}, 3'b100);
      rx_byte(8'h10); rx_byte(8'h11); rx_byte(8'h01);
      idle(6);
      #5 chk(!hdr_valid && !fwd_valid, "R12 hand-off bytes ignored", hdr_valid, 0);
      pps_done = 1'b1;
      idle(1);
      pps_done = 1'b0;
      header(8'h80, 8'hCA, 8'h9F, 8'h7F, 8'h00);
      #5 chk(hdr_bus == 40'h80CA9F7F00, "R12 header after hand-off", hdr_bus, 40'h80CA9F7F00);
      host_byte(8'h6C, 3'b000, 1'b0);
      host_byte(8'h00, 3'b100, 1'b1);
      idle(4);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule